// File: doc/BRIEF.md
# UART FIFO Interrupt and Status Logic

This block is the decision layer between a UART's transmit and receive FIFOs and the host processor. The FIFOs, shifters and register decoding live elsewhere and report to this block through occupancy counts, flags and one-cycle access strobes. From these it forms the line status byte, two interrupt sources (receive data at threshold, transmit FIFO drained), a combined interrupt line with a source code, and the two active-low DMA ready pins.

The receive interrupt is a level that follows occupancy against a selectable threshold and clears itself once the FIFO drains below it. The transmit interrupt is an event that is held until the host reads the interrupt status or writes new transmit data. The DMA pins use single-transfer semantics by default. When block mode is selected and the FIFOs are on, they switch to burst semantics.

Top module: `uart_fifo_irq_status`

## Requirements
- R1: The receive threshold is chosen by `trig_sel`: 0 selects 1 byte, 1 selects 4, 2 selects 8 and 3 selects 14. With `fifo_en`=0 the threshold is 1. `rx_irq` is high in the same cycle that `rx_irq_en`=1 and `rx_count` is at or above the threshold, and it drops in the same cycle that the count falls below it.
- R2: `isr_id` is 4'b0100 while `rx_irq` is high. Otherwise it is 4'b0010 while `tx_irq` is high. Otherwise it is 4'b0001. The receive source wins when both are present.
- R3: `lsr[0]` is 1 whenever `rx_count` is nonzero, from the cycle the first byte arrives, and 0 when the count is zero.
- R4: A transmit-empty event is recorded when `tx_count` is zero in a cycle and was nonzero in the previous cycle. `tx_irq` rises one cycle later if `tx_irq_en`=1. The event is held while the enable is low.
- R5: An `isr_rd` or `thr_wr` pulse clears the pending transmit event from the next cycle, and it takes priority over a simultaneous new event. No new event is raised until the FIFO holds data and empties again.
- R6: With `rx_irq_en`=0 and `tx_irq_en`=0, `irq`, `rx_irq` and `tx_irq` are all 0 and `isr_id` is 4'b0001. All `lsr` bits keep updating.
- R7: `lsr[5]` is 1 when `tx_count` is zero. `lsr[6]` is 1 when `tx_count` is zero and `tx_shift_empty`=1.
- R8: `lsr[4:1]` pass `rx_head_err[3:0]` through unchanged. `lsr[7]` is 1 when `fifo_en`=1 and `rx_err_count` is nonzero.
- R9: In single-transfer mode (`dma_blk`=0 or `fifo_en`=0), `txrdy_n` is 0 exactly when `tx_count` is zero, and `rxrdy_n` is 0 exactly when `rx_count` is nonzero.
- R10: In block mode (`dma_blk`=1 and `fifo_en`=1), `txrdy_n` is 1 only when `tx_count` equals the FIFO depth (16). `rxrdy_n` goes 0 in the cycle the count reaches the threshold and stays 0 until the count is zero. The burst latch tracks this in every mode.
- R11: `irq` is the OR of `rx_irq` and `tx_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | FIFOs enabled |
| dma_blk | input | 1 | DMA block (burst) mode select |
| trig_sel | input | 2 | Receive threshold select |
| rx_irq_en | input | 1 | Receive interrupt enable |
| tx_irq_en | input | 1 | Transmit-empty interrupt enable |
| rx_count | input | 5 | Receive FIFO occupancy |
| rx_err_count | input | 5 | Number of errored bytes held in the receive FIFO |
| rx_head_err | input | 4 | Error flags of the byte at the receive FIFO head |
| tx_count | input | 5 | Transmit FIFO occupancy |
| tx_shift_empty | input | 1 | Transmit shift register idle |
| isr_rd | input | 1 | One-cycle pulse: host read interrupt status |
| thr_wr | input | 1 | One-cycle pulse: host wrote transmit data |
| lsr | output | 8 | Line status byte |
| rx_irq | output | 1 | Receive threshold interrupt |
| tx_irq | output | 1 | Transmit-empty interrupt |
| irq | output | 1 | Combined interrupt |
| isr_id | output | 4 | Interrupt source code |
| txrdy_n | output | 1 | Transmit DMA ready, active low |
| rxrdy_n | output | 1 | Receive DMA ready, active low |

## Verification
All outputs except `tx_irq` are combinational in the current inputs and the burst latch, so they are due in the same cycle the stimulus is applied. `tx_irq` is due one cycle after the draining or clearing cycle, and that delay also reaches `irq` and `isr_id`. The bench changes inputs just after the rising edge and compares every output at the falling edge of that cycle. Its reference model updates the pending transmit event and the burst latch at the rising edge, using the inputs as they stood, which gives the one-cycle lag exactly.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [3:0] {
    SRC_NONE    = 4'b0001,
    SRC_TXEMPTY = 4'b0010,
    SRC_RXDATA  = 4'b0100
  } irq_src_e;

  // Receive threshold in bytes for a given select code; FIFO off means 1.
  function automatic int unsigned rx_threshold(input logic [1:0] sel,
                                               input logic fifo_on);
    int unsigned lvl;
    case (sel)
      2'd0:    lvl = 1;
      2'd1:    lvl = 4;
      2'd2:    lvl = 8;
      default: lvl = 14;
    endcase
    return fifo_on ? lvl : 1;
  endfunction

  // Source code, receive side first.
  function automatic irq_src_e pick_source(input logic rx_act, input logic tx_act);
    if (rx_act)      return SRC_RXDATA;
    else if (tx_act) return SRC_TXEMPTY;
    else             return SRC_NONE;
  endfunction

endpackage

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_irq_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          blk_mode,
  input  logic [1:0]    trig_sel,
  input  logic          rx_irq_en,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] rx_err_count,
  output logic          rx_irq,
  output logic          lsr_dr,
  output logic          lsr_err_any,
  output logic          rxrdy_n
);

  logic [CW-1:0] thr_lvl;
  logic          rx_hit;       // occupancy at or above threshold
  logic          rx_nonempty;
  logic          burst_q;      // burst latch state
  logic          burst_act;    // burst ready indication this cycle

  assign thr_lvl     = CW'(rx_threshold(trig_sel, fifo_en));
  assign rx_hit      = (rx_count >= thr_lvl);
  assign rx_nonempty = (rx_count != '0);

  assign rx_irq      = rx_irq_en & rx_hit;
  assign lsr_dr      = rx_nonempty;
  assign lsr_err_any = fifo_en & (rx_err_count != '0);

  assign burst_act = rx_hit | (burst_q & rx_nonempty);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) burst_q <= 1'b0;
    else        burst_q <= burst_act;
  end

  assign rxrdy_n = blk_mode ? ~burst_act : ~rx_nonempty;

  // R1
  rx_irq_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> lsr_dr);

  // R10
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_mode && !rxrdy_n && !rx_hit) |-> (burst_q && rx_nonempty));

  // R9
  single_rxrdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk_mode && lsr_dr) |-> !rxrdy_n);

endmodule

// File: rtl/uart_tx_status.sv
module uart_tx_status #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          blk_mode,
  input  logic          tx_irq_en,
  input  logic [CW-1:0] tx_count,
  input  logic          tx_shift_empty,
  input  logic          isr_rd,
  input  logic          thr_wr,
  output logic          tx_irq,
  output logic          lsr_thre,
  output logic          lsr_temt,
  output logic          txrdy_n
);

  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

  logic tx_empty;
  logic prev_empty_q;  // emptiness seen in the previous cycle
  logic drain_evt;     // transition into empty this cycle
  logic host_ack;      // status read or data write
  logic pend_q;

  assign tx_empty  = (tx_count == '0);
  assign drain_evt = tx_empty & ~prev_empty_q;
  assign host_ack  = isr_rd | thr_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_empty_q <= 1'b1;
      pend_q       <= 1'b0;
    end else begin
      prev_empty_q <= tx_empty;
      if (host_ack)       pend_q <= 1'b0;
      else if (drain_evt) pend_q <= 1'b1;
    end
  end

  assign tx_irq   = tx_irq_en & pend_q;
  assign lsr_thre = tx_empty;
  assign lsr_temt = tx_empty & tx_shift_empty;
  assign txrdy_n  = blk_mode ? (tx_count == FULL_LVL) : ~tx_empty;

  // R4
  drain_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_evt && !host_ack) |=> pend_q);

  // R5
  ack_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |=> !pend_q);

  // R7
  temt_implies_thre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_temt |-> lsr_thre);

  // R9
  single_txrdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk_mode && lsr_thre) |-> !txrdy_n);

endmodule

// File: rtl/uart_isr_encode.sv
module uart_isr_encode
  import uart_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_irq,
  input  logic       tx_irq,
  output logic       irq,
  output logic [3:0] isr_id
);

  irq_src_e src;

  assign src    = pick_source(rx_irq, tx_irq);
  assign isr_id = src;
  assign irq    = rx_irq | tx_irq;

  // R2
  rx_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (isr_id == 4'b0100));

  // R11
  irq_matches_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (isr_id != 4'b0001));

endmodule

// File: rtl/uart_fifo_irq_status.sv
module uart_fifo_irq_status
  import uart_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          dma_blk,
  input  logic [1:0]    trig_sel,
  input  logic          rx_irq_en,
  input  logic          tx_irq_en,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] rx_err_count,
  input  logic [3:0]    rx_head_err,
  input  logic [CW-1:0] tx_count,
  input  logic          tx_shift_empty,
  input  logic          isr_rd,
  input  logic          thr_wr,
  output logic [7:0]    lsr,
  output logic          rx_irq,
  output logic          tx_irq,
  output logic          irq,
  output logic [3:0]    isr_id,
  output logic          txrdy_n,
  output logic          rxrdy_n
);

  logic blk_eff;
  logic lsr_dr, lsr_err_any, lsr_thre, lsr_temt;

  assign blk_eff = dma_blk & fifo_en;

  uart_rx_status #(.CW(CW)) u_rx (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .blk_mode(blk_eff),
    .trig_sel(trig_sel), .rx_irq_en(rx_irq_en), .rx_count(rx_count),
    .rx_err_count(rx_err_count), .rx_irq(rx_irq), .lsr_dr(lsr_dr),
    .lsr_err_any(lsr_err_any), .rxrdy_n(rxrdy_n)
  );

  uart_tx_status #(.DEPTH(DEPTH), .CW(CW)) u_tx (
    .clk(clk), .rst_n(rst_n), .blk_mode(blk_eff), .tx_irq_en(tx_irq_en),
    .tx_count(tx_count), .tx_shift_empty(tx_shift_empty), .isr_rd(isr_rd),
    .thr_wr(thr_wr), .tx_irq(tx_irq), .lsr_thre(lsr_thre),
    .lsr_temt(lsr_temt), .txrdy_n(txrdy_n)
  );

  uart_isr_encode u_isr (
    .clk(clk), .rst_n(rst_n), .rx_irq(rx_irq), .tx_irq(tx_irq),
    .irq(irq), .isr_id(isr_id)
  );

  assign lsr = {lsr_err_any, lsr_temt, lsr_thre, rx_head_err, lsr_dr};

  // R6
  polled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_irq_en && !tx_irq_en) |-> (!irq && isr_id == 4'b0001));

  // R10
  blk_txrdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_eff && txrdy_n) |-> (tx_count == CW'(DEPTH)));

endmodule

// File: tb/sim_uart_fifo_irq_status.sv
module sim_uart_fifo_irq_status;
  localparam int DEPTH = 16;
  localparam int CW = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic fifo_en = 1'b1, dma_blk = 1'b0, rx_irq_en = 1'b0, tx_irq_en = 1'b0;
  logic [1:0] trig_sel = 2'd0;
  logic [CW-1:0] rx_count = '0, rx_err_count = '0, tx_count = '0;
  logic [3:0] rx_head_err = '0;
  logic tx_shift_empty = 1'b1, isr_rd = 1'b0, thr_wr = 1'b0;
  logic [7:0] lsr;
  logic rx_irq, tx_irq, irq, txrdy_n, rxrdy_n;
  logic [3:0] isr_id;

  uart_fifo_irq_status #(.DEPTH(DEPTH)) u0 (.*);

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FIFO-STATUS FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Reference model state
  bit m_pend = 0, m_prev_nz = 0, m_burst = 0;

  function automatic int thresh();
    if (!fifo_en) return 1;
    if (trig_sel == 2'd3) return 14;
    if (trig_sel == 2'd2) return 8;
    if (trig_sel == 2'd1) return 4;
    return 1;
  endfunction

  function automatic bit hit();
    return int'(rx_count) >= thresh();
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend <= 0; m_prev_nz <= 0; m_burst <= 0;
    end else begin
      if (isr_rd || thr_wr) m_pend <= 0;
      else if (tx_count == 0 && m_prev_nz) m_pend <= 1;
      m_prev_nz <= (tx_count != 0);
      m_burst <= hit() || (m_burst && rx_count != 0);
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      bit e_rx, e_tx, blk, burst;
      logic [3:0] e_id;
      e_rx = rx_irq_en && hit();
      e_tx = tx_irq_en && m_pend;
      e_id = e_rx ? 4'b0100 : (e_tx ? 4'b0010 : 4'b0001);
      blk = dma_blk && fifo_en;
      burst = hit() || (m_burst && rx_count != 0);
      chk("R1 rx_irq", {7'd0, rx_irq}, {7'd0, e_rx});
      chk("R4/R5 tx_irq", {7'd0, tx_irq}, {7'd0, e_tx});
      chk("R11 irq", {7'd0, irq}, {7'd0, e_rx | e_tx});
      chk("R2 isr_id", {4'd0, isr_id}, {4'd0, e_id});
      chk("R3 lsr0", {7'd0, lsr[0]}, {7'd0, rx_count != 0});
      chk("R8 lsr4_1", {4'd0, lsr[4:1]}, {4'd0, rx_head_err});
      chk("R7 lsr5", {7'd0, lsr[5]}, {7'd0, tx_count == 0});
      chk("R7 lsr6", {7'd0, lsr[6]}, {7'd0, tx_count == 0 && tx_shift_empty});
      chk("R8 lsr7", {7'd0, lsr[7]}, {7'd0, fifo_en && rx_err_count != 0});
      if (blk) begin
        chk("R10 txrdy_n", {7'd0, txrdy_n}, {7'd0, int'(tx_count) == DEPTH});
        chk("R10 rxrdy_n", {7'd0, rxrdy_n}, {7'd0, !burst});
      end else begin
        chk("R9 txrdy_n", {7'd0, txrdy_n}, {7'd0, tx_count != 0});
        chk("R9 rxrdy_n", {7'd0, rxrdy_n}, {7'd0, rx_count == 0});
      end
      if (!rx_irq_en && !tx_irq_en)
        chk("R6 polled irq", {7'd0, irq}, 8'd0);
    end
  end

  task automatic cyc(input int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic pulse_rd();
    isr_rd = 1; cyc(); isr_rd = 0;
  endtask

  task automatic pulse_wr();
    thr_wr = 1; cyc(); thr_wr = 0;
  endtask

  task automatic rx_sweep();
    for (int i = 0; i <= DEPTH; i++) begin rx_count = CW'(i); cyc(); end
    for (int i = DEPTH; i >= 0; i--) begin rx_count = CW'(i); cyc(); end
  endtask

  task automatic tx_sweep();
    for (int i = 0; i <= DEPTH; i++) begin tx_count = CW'(i); cyc(); end
    for (int i = DEPTH; i >= 0; i--) begin tx_count = CW'(i); tx_shift_empty = (i == 0); cyc(); end
  endtask

  initial begin
    #(200000 * 10);
    n_fail++; n_chk++;
    $display("FIFO-STATUS FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    cyc(2);
    @(negedge clk);
    chk("R4 reset tx_irq", {7'd0, tx_irq}, 8'd0);
    chk("R2 reset isr_id", {4'd0, isr_id}, 8'h01);
    chk("R7 reset lsr", lsr, 8'h60);
    rst_n = 1; cmp_on = 1;
    cyc(2);

    // threshold sweep for every select code
    rx_irq_en = 1;
    for (int s = 0; s < 4; s++) begin trig_sel = 2'(s); rx_sweep(); end
    trig_sel = 2'd2; rx_count = 5'd7; cyc();
    @(negedge clk); chk("R1 below 8", {7'd0, rx_irq}, 8'd0);
    rx_count = 5'd8; cyc();
    @(negedge clk); chk("R1 at 8", {7'd0, rx_irq}, 8'd1);
    rx_count = 0; cyc();

    // transmit-empty event and its clearing
    tx_irq_en = 1; tx_shift_empty = 0;
    tx_sweep(); cyc();
    @(negedge clk); chk("R4 drained", {7'd0, tx_irq}, 8'd1);
    pulse_rd(); cyc(3);
    @(negedge clk); chk("R5 cleared by read", {7'd0, tx_irq}, 8'd0);
    tx_count = 5'd2; thr_wr = 1; cyc(); thr_wr = 0;
    tx_count = 5'd0; cyc(2);
    @(negedge clk); chk("R4 second drain", {7'd0, tx_irq}, 8'd1);
    pulse_wr(); cyc();
    @(negedge clk); chk("R5 cleared by write", {7'd0, tx_irq}, 8'd0);
    // clear wins over same-cycle drain
    tx_count = 5'd1; cyc(); tx_count = 0; isr_rd = 1; cyc(); isr_rd = 0; cyc();
    @(negedge clk); chk("R5 clear priority", {7'd0, tx_irq}, 8'd0);
    // held while disabled
    tx_irq_en = 0; tx_count = 5'd3; cyc(); tx_count = 0; cyc(2);
    tx_irq_en = 1; cyc();
    @(negedge clk); chk("R4 held pending", {7'd0, tx_irq}, 8'd1);
    pulse_rd();

    // polled mode
    rx_irq_en = 0; tx_irq_en = 0; trig_sel = 2'd1;
    rx_err_count = 5'd1; rx_head_err = 4'b1010;
    rx_sweep(); tx_sweep();
    rx_err_count = 0; rx_head_err = 0;

    // block DMA mode
    dma_blk = 1; rx_irq_en = 1; tx_irq_en = 1;
    for (int s = 0; s < 4; s++) begin trig_sel = 2'(s); rx_sweep(); end
    trig_sel = 2'd2; rx_count = 5'd9; cyc(); rx_count = 5'd3; cyc();
    @(negedge clk); chk("R10 burst held", {7'd0, rxrdy_n}, 8'd0);
    rx_count = 0; cyc();
    @(negedge clk); chk("R10 burst released", {7'd0, rxrdy_n}, 8'd1);
    tx_sweep();
    tx_count = 5'd16; cyc();
    @(negedge clk); chk("R10 tx full", {7'd0, txrdy_n}, 8'd1);
    tx_count = 0; cyc();

    // FIFOs off
    fifo_en = 0; rx_err_count = 5'd2; trig_sel = 2'd3;
    rx_sweep(); tx_sweep();
    fifo_en = 1;

    // random walk
    for (int i = 0; i < 4000; i++) begin
      int r;
      if (i % 150 == 0) begin
        fifo_en = 1'($urandom_range(0, 5) != 0);
        dma_blk = 1'($urandom_range(0, 1));
        trig_sel = 2'($urandom_range(0, 3));
        rx_irq_en = 1'($urandom_range(0, 1));
        tx_irq_en = 1'($urandom_range(0, 1));
      end
      r = int'(rx_count) + $urandom_range(0, 2) - 1;
      if (r < 0) r = 0; if (r > DEPTH) r = DEPTH;
      rx_count = CW'(r);
      rx_err_count = CW'($urandom_range(0, r));
      rx_head_err = 4'($urandom_range(0, 15));
      r = int'(tx_count) + $urandom_range(0, 2) - 1;
      if (r < 0) r = 0; if (r > DEPTH) r = DEPTH;
      tx_count = CW'(r);
      tx_shift_empty = 1'($urandom_range(0, 1));
      isr_rd = ($urandom_range(0, 9) == 0);
      thr_wr = ($urandom_range(0, 9) == 0);
      cyc();
    end
    isr_rd = 0; thr_wr = 0; cyc(2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule